// File: doc/BRIEF.md
# Pointer-Relative Wrapping Immediate Loader

This block writes a short constant, one nibble at a time, into a wide register made of nibbles. The caller gives a start pointer and a length of 1 to 16 nibbles, then supplies the constant one nibble per cycle, lowest nibble first. The first nibble lands at the pointed-to position. Each later nibble goes one position higher. After the top position the index wraps back to position 0, so a long constant can fill the top of the register and then continue at its bottom.

Positions the load does not reach keep their old contents. The pointer and the length are captured when the load is accepted, so later changes on those inputs do not affect a load that is running. A busy flag covers the write cycles. A one-cycle done pulse follows the last write.

Top module: `ptr_imm_loader`

## Requirements
- R1: After a synchronous active-low reset, reg_out is all zeros and busy and done are 0.
- R2: A start seen at a clock edge while busy is 0 and load_count is in 1..16 is accepted. busy is then 1 for exactly load_count cycles, starting in the cycle after that edge.
- R3: The nibble on imm_nib at the k-th clock edge after acceptance (k = 0 for the first) is written to nibble (ptr + k) mod 16, which is reg_out bits [4i+3:4i] for index i. Here ptr is the value of ptr_in at acceptance.
- R4: The write index wraps from nibble 15 to nibble 0. For example, ptr 9 with count 8 writes nibbles 9 to 15 and then nibble 0.
- R5: Nibbles outside the loaded range keep their previous values.
- R6: A count of 16 overwrites all 16 nibbles, with the lowest constant nibble at index ptr.
- R7: Changes on ptr_in and load_count after acceptance do not affect a load in progress.
- R8: done is 1 for exactly one cycle, in the cycle right after the last write, and busy is 0 in that cycle.
- R9: A start raised while busy is 1 is ignored.
- R10: A start with load_count equal to 0 or greater than 16 is ignored: busy stays 0 and reg_out is unchanged.
- R11: While busy is 0, imm_nib has no effect on reg_out, and at most one nibble of reg_out changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a load |
| load_count | input | 5 | Number of nibbles to load, 1..16 |
| ptr_in | input | 4 | Start nibble index |
| imm_nib | input | 4 | Constant nibble for the current write cycle |
| reg_out | output | 64 | Target nibble register |
| busy | output | 1 | Load in progress; a nibble is consumed each cycle |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The accepting edge is the edge where start is sampled. busy rises in the cycle after that edge. The nibble driven in that cycle is written at the next edge, and each following cycle's nibble is written one edge later. For a count of n, done and the final register value appear in the cycle after the n-th write edge.

The bench drives all inputs on the falling edge and samples all outputs on the falling edge. It checks busy during every write cycle, and done, busy and reg_out in the cycle after the last write. It checks that done has dropped one cycle later. For rejected starts and idle stimulus, it checks reg_out and busy one cycle after the ignored input.

// File: rtl/ptrload_pkg.sv
// Shared types for the pointer-relative immediate loader.
// Assumes nothing beyond a two-state load sequence.
package ptrload_pkg;
    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_RUN  = 1'b1
    } ld_state_t;
endpackage

// File: rtl/ptrload_ctrl.sv
// Sequencer: accepts a start, latches pointer and length, then produces one
// write index per cycle, wrapping at the top nibble. Assumes the caller
// supplies one nibble per cycle while busy is high.
module ptrload_ctrl
    import ptrload_pkg::*;
#(
    parameter int NIB_CNT = 16,
    localparam int IDX_W = $clog2(NIB_CNT),
    localparam int CNT_W = $clog2(NIB_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_count,
    input  logic [IDX_W-1:0] ptr_in,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             busy,
    output logic             done
);
    ld_state_t        state_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] left_q;
    logic             done_q;
    logic             cnt_ok;
    logic             accept;
    logic             last;
    logic [IDX_W-1:0] idx_nxt;

    // Decide whether a start request is legal this cycle.
    always_comb begin
        cnt_ok = (load_count != '0) && (load_count <= CNT_W'(NIB_CNT));
        accept = start && (state_q == LD_IDLE) && cnt_ok;
        last   = (state_q == LD_RUN) && (left_q == CNT_W'(1));
    end

    // Next write index, wrapping from the top nibble to nibble 0.
    always_comb begin
        if (idx_q == IDX_W'(NIB_CNT - 1)) idx_nxt = '0;
        else                              idx_nxt = idx_q + 1'b1;
    end

    // State, latched pointer and remaining-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            idx_q   <= '0;
            left_q  <= '0;
        end else if (accept) begin
            state_q <= LD_RUN;
            idx_q   <= ptr_in;
            left_q  <= load_count;
        end else if (state_q == LD_RUN) begin
            idx_q  <= idx_nxt;
            left_q <= left_q - 1'b1;
            if (last) state_q <= LD_IDLE;
        end
    end

    // Completion pulse, raised for the cycle after the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last;
    end

    assign wr_en  = (state_q == LD_RUN);
    assign wr_idx = idx_q;
    assign busy   = (state_q == LD_RUN);
    assign done   = done_q;
endmodule

// File: rtl/ptrload_nibfile.sv
// Nibble register: one slot per nibble, written one slot at a time by index.
// Assumes wr_idx is below NIB_CNT whenever wr_en is high.
module ptrload_nibfile #(
    parameter int NIB_W   = 4,
    parameter int NIB_CNT = 16,
    localparam int IDX_W = $clog2(NIB_CNT),
    localparam int REG_W = NIB_W * NIB_CNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [NIB_W-1:0] wr_nib,
    output logic [REG_W-1:0] reg_q
);
    for (genvar g = 0; g < NIB_CNT; g++) begin : g_slot
        logic [NIB_W-1:0] slot_q;

        // Hold this slot unless it is the one being written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  slot_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))     slot_q <= wr_nib;
        end

        assign reg_q[g*NIB_W +: NIB_W] = slot_q;
    end
endmodule

// File: rtl/ptr_imm_loader.sv
// Top: loads a 1..NIB_CNT nibble constant into a nibble register, starting at
// a latched pointer and wrapping modulo NIB_CNT. Assumes one nibble per busy cycle.
module ptr_imm_loader #(
    parameter int NIB_W   = 4,
    parameter int NIB_CNT = 16,
    localparam int IDX_W = $clog2(NIB_CNT),
    localparam int CNT_W = $clog2(NIB_CNT + 1),
    localparam int REG_W = NIB_W * NIB_CNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_count,
    input  logic [IDX_W-1:0] ptr_in,
    input  logic [NIB_W-1:0] imm_nib,
    output logic [REG_W-1:0] reg_out,
    output logic             busy,
    output logic             done
);
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    ptrload_ctrl #(.NIB_CNT(NIB_CNT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .load_count (load_count),
        .ptr_in     (ptr_in),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .busy       (busy),
        .done       (done)
    );

    ptrload_nibfile #(.NIB_W(NIB_W), .NIB_CNT(NIB_CNT)) u_file (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_nib (imm_nib),
        .reg_q  (reg_out)
    );
endmodule

// File: rtl/ptr_imm_loader_chk.sv
// Port-level property checker for ptr_imm_loader, attached by bind below.
// Assumes synchronous active-low reset.
module ptr_imm_loader_chk #(
    parameter int NIB_W   = 4,
    parameter int NIB_CNT = 16,
    localparam int IDX_W = $clog2(NIB_CNT),
    localparam int CNT_W = $clog2(NIB_CNT + 1),
    localparam int REG_W = NIB_W * NIB_CNT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] load_count,
    input logic [IDX_W-1:0] ptr_in,
    input logic [NIB_W-1:0] imm_nib,
    input logic [REG_W-1:0] reg_out,
    input logic             busy,
    input logic             done
);
    logic [REG_W-1:0]   prev_q;
    logic [NIB_CNT-1:0] diff;
    logic               good_cnt;

    // Keep last cycle's register image to count changed nibbles.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= reg_out;
    end

    for (genvar g = 0; g < NIB_CNT; g++) begin : g_diff
        assign diff[g] = prev_q[g*NIB_W +: NIB_W] != reg_out[g*NIB_W +: NIB_W];
    end

    assign good_cnt = (load_count != '0) && (load_count <= CNT_W'(NIB_CNT));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && good_cnt) |=> busy);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_bad_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !good_cnt) |=> (!busy && $stable(reg_out)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(reg_out));

    assert_one_nibble_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(diff) <= 1);
endmodule

bind ptr_imm_loader ptr_imm_loader_chk #(.NIB_W(NIB_W), .NIB_CNT(NIB_CNT)) u_chk (.*);

// File: tb/ptr_imm_loader_bench.sv
// Bench for ptr_imm_loader: directed corners plus seeded random loads.
module ptr_imm_loader_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  load_count = '0;
    logic [3:0]  ptr_in = '0;
    logic [3:0]  imm_nib = '0;
    logic [63:0] reg_out;
    logic        busy;
    logic        done;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [63:0] exp_reg = '0;
    logic [3:0]  nibs [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_imm_loader u_ptr_imm_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .load_count(load_count),
        .ptr_in(ptr_in), .imm_nib(imm_nib), .reg_out(reg_out),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected register after loading cnt nibbles from p with wrap.
    function automatic logic [63:0] model(input logic [63:0] r, input int p, input int cnt);
        logic [63:0] v = r;
        for (int k = 0; k < cnt; k++) v[((p + k) % 16) * 4 +: 4] = nibs[k];
        return v;
    endfunction

    // Run one load, scrambling ptr/count during it; optionally poke start mid-load.
    task automatic run_load(input int p, input int cnt, input bit poke, input string req);
        @(negedge clk);
        start = 1'b1; load_count = 5'(cnt); ptr_in = 4'(p);
        for (int k = 0; k < cnt; k++) begin
            @(negedge clk);
            start = (poke && k == 0 && cnt > 2);   // R9: start while busy
            ptr_in = 4'($urandom);                  // R7: changes after acceptance
            load_count = 5'($urandom_range(1, 16));
            imm_nib = nibs[k];
            check(busy === 1'b1, "R2 busy during load", 64'(busy), 64'd1);
        end
        @(negedge clk);
        start = 1'b0;
        exp_reg = model(exp_reg, p, cnt);
        check(done === 1'b1 && busy === 1'b0, "R8 done after last write",
              {62'd0, done, busy}, 64'd2);
        check(reg_out === exp_reg, req, reg_out, exp_reg);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R8/R9 single pulse, no relaunch",
              {62'd0, done, busy}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd7281));
        repeat (3) @(negedge clk);
        check(reg_out === 64'd0 && busy === 1'b0 && done === 1'b0, "R1 reset state",
              reg_out, 64'd0);
        rst_n = 1'b1;

        // R6: full load at pointer 5, rotated placement
        for (int k = 0; k < 16; k++) nibs[k] = 4'(k + 1);
        run_load(5, 16, 1'b0, "R6 full rotated load");
        // R3: single nibble at pointer 0
        nibs[0] = 4'hA;
        run_load(0, 1, 1'b0, "R3 single nibble");
        // R4/R5: pointer 9, count 8 wraps to nibble 0
        for (int k = 0; k < 8; k++) nibs[k] = 4'(15 - k);
        run_load(9, 8, 1'b0, "R4 wrap 9..15,0 and R5 untouched");
        // R4: pointer 15, count 2
        nibs[0] = 4'h3; nibs[1] = 4'hC;
        run_load(15, 2, 1'b0, "R4 wrap from 15");
        // R9: start while busy
        for (int k = 0; k < 6; k++) nibs[k] = 4'(k * 3);
        run_load(12, 6, 1'b1, "R9 start during load ignored");

        // R10: illegal counts
        @(negedge clk); start = 1'b1; load_count = 5'd0; ptr_in = 4'd3;
        @(negedge clk); start = 1'b0;
        check(busy === 1'b0 && reg_out === exp_reg, "R10 count 0 ignored", reg_out, exp_reg);
        @(negedge clk); start = 1'b1; load_count = 5'd20; imm_nib = 4'h7;
        @(negedge clk); start = 1'b0;
        check(busy === 1'b0 && reg_out === exp_reg, "R10 count 20 ignored", reg_out, exp_reg);

        // R11: imm_nib toggling while idle
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); imm_nib = 4'($urandom);
        end
        @(negedge clk);
        check(reg_out === exp_reg, "R11 idle imm_nib ignored", reg_out, exp_reg);

        // Random loads (R3, R5)
        for (int t = 0; t < 40; t++) begin
            int p = $urandom_range(0, 15);
            int c = $urandom_range(1, 16);
            for (int k = 0; k < 16; k++) nibs[k] = 4'($urandom);
            run_load(p, c, t[0], "R3 random load");
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule